// File: doc/BRIEF.md
# System Exception Pend and Reset Control Registers

This block is a small word-addressed register file that sits beside an interrupt controller core. Software writes it to raise or withdraw pending requests for three system exceptions: the non-maskable one, the software service-call one and the periodic timer one. It can also pend an external interrupt by its number, keep the vector table base address, keep the enable bits of three fault handlers, and request a whole-system reset. The reset request is honoured only when a 16-bit key is present in the upper half of the write.

The controller core is not part of the block. It sees the block only as single-cycle strobes: pend, clear-pending, and pend-external with a number. The core reports its pending state back on four status inputs, and a read of the state register reflects them. Every output is registered. A read returns its data one cycle after the read strobe. Offsets are given as byte offsets. The bus carries the word index, which is the byte offset shifted right by two.

Top module: `sys_pend_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, every strobe output is low, the vector base output is 0, the fault enable output is 0 and the read data is 0.
- R2: A write to the state register (byte 0xD04, word 0x341) with bit 31 set raises the non-maskable pend strobe for one cycle.
- R3: In the state register, bit 28 raises the service-call pend strobe and bit 27 raises its clear strobe. When both bits are 1, only the pend strobe rises.
- R4: In the state register, bit 26 raises the timer pend strobe and bit 25 raises its clear strobe. When both bits are 1, only the pend strobe rises.
- R5: A read of the state register returns the non-maskable pending input in bit 31, the service-call pending input in bit 28, the timer pending input in bit 26 and the any-external-pending input in bit 22. All other bits read 0.
- R6: The vector base register (byte 0xD08, word 0x342) stores the written word with bits [6:0] cleared. It drives that value on the vector base output, returns it on read, and holds it when no write reaches it.
- R7: A write to the reset control register (byte 0xD0C, word 0x343) raises the system reset request for exactly one cycle, and only when bits [31:16] equal 0x05FA and bit 2 is 1. Otherwise no request is raised.
- R8: The reset control register reads as 0xFA050000.
- R9: The handler control register (byte 0xD24, word 0x349) stores write bits 18:16 as the three fault handler enables. It drives them on the fault enable output (bit 0 from bit 16) and reads them back in bits 18:16, with all other bits 0.
- R10: A write to the trigger register (byte 0xF00, word 0x3C0) raises the external pend strobe for one cycle, carrying bits [8:0] as the number, only when that number is below IRQ_COUNT. Otherwise nothing is raised.
- R11: The type register (byte 0x004, word 0x001) reads as IRQ_COUNT/32 - 1.
- R12: Unmapped offsets read 0. Writes to them raise no strobe and change no stored register.
- R13: Each strobe is high only in the cycle after its write and falls in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr_i | input | ADDR_W | Word index of the register |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after the read |
| nmi_pending_i | input | 1 | Core: non-maskable exception pending |
| svc_pending_i | input | 1 | Core: service-call exception pending |
| tmr_pending_i | input | 1 | Core: timer exception pending |
| ext_pending_i | input | 1 | Core: some external interrupt pending |
| nmi_pend_o | output | 1 | Pend the non-maskable exception |
| svc_pend_set_o | output | 1 | Pend the service-call exception |
| svc_pend_clr_o | output | 1 | Clear the service-call pending state |
| tmr_pend_set_o | output | 1 | Pend the timer exception |
| tmr_pend_clr_o | output | 1 | Clear the timer pending state |
| ext_pend_o | output | 1 | Pend the external interrupt on ext_pend_num_o |
| ext_pend_num_o | output | NUM_W | Number of the external interrupt to pend |
| sys_reset_req_o | output | 1 | System reset request pulse |
| vec_base_o | output | 32 | Vector table base address |
| fault_en_o | output | 3 | Fault handler enables |

## Verification
Each result is due one clock after its stimulus. A write issued at one rising edge shows up on the strobes, vec_base_o and fault_en_o straight after that edge. A read shows up on bus_rdata_o after the edge that samples it. The bench drives inputs on the falling edge and holds the strobe for a single rising edge. It checks at the next falling edge, which is exactly one register stage later. For strobe width it checks once more a full cycle after that, where the strobe must be low again.

// File: rtl/sys_pend_pkg.sv
package sys_pend_pkg;
  localparam int WORD_W = 10;
  localparam logic [WORD_W-1:0] W_TYPE    = 10'h001;
  localparam logic [WORD_W-1:0] W_STATE   = 10'h341;
  localparam logic [WORD_W-1:0] W_VBASE   = 10'h342;
  localparam logic [WORD_W-1:0] W_RSTCTL  = 10'h343;
  localparam logic [WORD_W-1:0] W_HANDLER = 10'h349;
  localparam logic [WORD_W-1:0] W_TRIG    = 10'h3C0;

  localparam logic [15:0] RESET_KEY     = 16'h05FA;
  localparam logic [31:0] RSTCTL_RDVAL  = 32'hFA05_0000;

  // Bit positions inside the state register
  localparam int B_NMI     = 31;
  localparam int B_SVC_SET = 28;
  localparam int B_SVC_CLR = 27;
  localparam int B_TMR_SET = 26;
  localparam int B_TMR_CLR = 25;
  localparam int B_EXT     = 22;

  localparam int FEN_LSB = 16;
  localparam int FEN_N   = 3;
  localparam int VB_LSB  = 7;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_TYPE, SEL_STATE, SEL_VBASE, SEL_RSTCTL, SEL_HANDLER, SEL_TRIG
  } reg_sel_e;
endpackage

// File: rtl/sys_pend_decode.sv
module sys_pend_decode
  import sys_pend_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o
);
  always_comb begin
    case (addr_i)
      ADDR_W'(W_TYPE):    sel_o = SEL_TYPE;
      ADDR_W'(W_STATE):   sel_o = SEL_STATE;
      ADDR_W'(W_VBASE):   sel_o = SEL_VBASE;
      ADDR_W'(W_RSTCTL):  sel_o = SEL_RSTCTL;
      ADDR_W'(W_HANDLER): sel_o = SEL_HANDLER;
      ADDR_W'(W_TRIG):    sel_o = SEL_TRIG;
      default:            sel_o = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/sys_pend_strobe.sv
module sys_pend_strobe
  import sys_pend_pkg::*;
#(
  parameter int IRQ_COUNT = 64,
  parameter int NUM_W     = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we_i,
  input  reg_sel_e         sel_i,
  input  logic [15:0]      hi_i,
  input  logic [NUM_W-1:0] lo_i,
  output logic             nmi_o,
  output logic             svc_set_o,
  output logic             svc_clr_o,
  output logic             tmr_set_o,
  output logic             tmr_clr_o,
  output logic             ext_o,
  output logic [NUM_W-1:0] ext_num_o,
  output logic             rst_req_o
);
  localparam logic [NUM_W:0] COUNT_V = (NUM_W+1)'(IRQ_COUNT);
  localparam int H = 16;

  logic in_range;
  assign in_range = {1'b0, lo_i} < COUNT_V;

  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_o <= 1'b0; svc_set_o <= 1'b0; svc_clr_o <= 1'b0;
      tmr_set_o <= 1'b0; tmr_clr_o <= 1'b0; ext_o <= 1'b0;
      ext_num_o <= '0; rst_req_o <= 1'b0;
    end else begin
      nmi_o <= 1'b0; svc_set_o <= 1'b0; svc_clr_o <= 1'b0;
      tmr_set_o <= 1'b0; tmr_clr_o <= 1'b0; ext_o <= 1'b0;
      rst_req_o <= 1'b0;
      if (we_i) begin
        case (sel_i)
          SEL_STATE: begin
            nmi_o     <= hi_i[B_NMI-H];
            svc_set_o <= hi_i[B_SVC_SET-H];
            svc_clr_o <= hi_i[B_SVC_CLR-H] & ~hi_i[B_SVC_SET-H];
            tmr_set_o <= hi_i[B_TMR_SET-H];
            tmr_clr_o <= hi_i[B_TMR_CLR-H] & ~hi_i[B_TMR_SET-H];
          end
          SEL_RSTCTL: rst_req_o <= (hi_i == RESET_KEY) & lo_i[2];
          SEL_TRIG: if (in_range) begin
            ext_o     <= 1'b1;
            ext_num_o <= lo_i;
          end
          default: ;
        endcase
      end
    end
  end

  // R3: pend and clear of the service-call exception never together
  p_svc_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(svc_set_o && svc_clr_o));
  // R4: same for the timer exception
  p_tmr_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(tmr_set_o && tmr_clr_o));
  // R7: a reset request follows a keyed write
  p_rst_key_r7: assert property (@(posedge clk) disable iff (rst)
    rst_req_o |-> ($past(we_i) && $past(hi_i) == RESET_KEY));
  // R10: an external pend never carries an out-of-range number
  p_trig_bound_r10: assert property (@(posedge clk) disable iff (rst)
    ext_o |-> ({1'b0, ext_num_o} < COUNT_V));
endmodule

// File: rtl/sys_pend_store.sv
module sys_pend_store
  import sys_pend_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               we_i,
  input  reg_sel_e           sel_i,
  input  logic [31:VB_LSB]   vb_i,
  input  logic [FEN_N-1:0]   fen_i,
  output logic [31:0]        vbase_o,
  output logic [FEN_N-1:0]   fen_o
);
  logic [31:VB_LSB] vb_q;
  logic             vb_we;

  assign vb_we = we_i && (sel_i == SEL_VBASE);

  always_ff @(posedge clk) begin
    if (rst) begin
      vb_q  <= '0;
      fen_o <= '0;
    end else begin
      if (vb_we) vb_q <= vb_i;
      if (we_i && sel_i == SEL_HANDLER) fen_o <= fen_i;
    end
  end

  assign vbase_o = {vb_q, {VB_LSB{1'b0}}};

  // R6: the base address only moves after a write to it
  p_vbase_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !$past(vb_we) |-> $stable(vbase_o));
endmodule

// File: rtl/sys_pend_ctrl.sv
module sys_pend_ctrl
  import sys_pend_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int IRQ_COUNT = 64,
  parameter int NUM_W     = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  input  logic              nmi_pending_i,
  input  logic              svc_pending_i,
  input  logic              tmr_pending_i,
  input  logic              ext_pending_i,
  output logic              nmi_pend_o,
  output logic              svc_pend_set_o,
  output logic              svc_pend_clr_o,
  output logic              tmr_pend_set_o,
  output logic              tmr_pend_clr_o,
  output logic              ext_pend_o,
  output logic [NUM_W-1:0]  ext_pend_num_o,
  output logic              sys_reset_req_o,
  output logic [31:0]       vec_base_o,
  output logic [2:0]        fault_en_o
);
  localparam logic [31:0] TYPE_VAL = 32'(IRQ_COUNT / 32 - 1);

  reg_sel_e    sel;
  logic [31:0] rd_next;

  sys_pend_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i(bus_addr_i), .sel_o(sel)
  );

  sys_pend_strobe #(.IRQ_COUNT(IRQ_COUNT), .NUM_W(NUM_W)) u_stb (
    .clk(clk), .rst(rst), .we_i(bus_wr_i), .sel_i(sel),
    .hi_i(bus_wdata_i[31:16]), .lo_i(bus_wdata_i[NUM_W-1:0]),
    .nmi_o(nmi_pend_o), .svc_set_o(svc_pend_set_o), .svc_clr_o(svc_pend_clr_o),
    .tmr_set_o(tmr_pend_set_o), .tmr_clr_o(tmr_pend_clr_o),
    .ext_o(ext_pend_o), .ext_num_o(ext_pend_num_o), .rst_req_o(sys_reset_req_o)
  );

  sys_pend_store u_sto (
    .clk(clk), .rst(rst), .we_i(bus_wr_i), .sel_i(sel),
    .vb_i(bus_wdata_i[31:VB_LSB]), .fen_i(bus_wdata_i[FEN_LSB+FEN_N-1:FEN_LSB]),
    .vbase_o(vec_base_o), .fen_o(fault_en_o)
  );

  always_comb begin
    rd_next = '0;
    case (sel)
      SEL_TYPE:    rd_next = TYPE_VAL;
      SEL_STATE: begin
        rd_next[B_NMI]     = nmi_pending_i;
        rd_next[B_SVC_SET] = svc_pending_i;
        rd_next[B_TMR_SET] = tmr_pending_i;
        rd_next[B_EXT]     = ext_pending_i;
      end
      SEL_VBASE:   rd_next = vec_base_o;
      SEL_RSTCTL:  rd_next = RSTCTL_RDVAL;
      SEL_HANDLER: rd_next[FEN_LSB+FEN_N-1:FEN_LSB] = fault_en_o;
      default:     rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)           bus_rdata_o <= '0;
    else if (bus_rd_i) bus_rdata_o <= rd_next;
  end

  // R12: read data changes only after a read strobe
  p_rdata_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_rd_i) |-> $stable(bus_rdata_o));
endmodule

// File: tb/sys_pend_ctrl_tb.sv
module sys_pend_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [9:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        nmi_p = 0, svc_p = 0, tmr_p = 0, ext_p = 0;
  logic        nmi_s, svc_s, svc_c, tmr_s, tmr_c, ext_s, rreq;
  logic [8:0]  ext_num;
  logic [31:0] vbase;
  logic [2:0]  fen;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sys_pend_ctrl u_dut (
    .clk(clk), .rst(rst), .bus_addr_i(addr), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .nmi_pending_i(nmi_p), .svc_pending_i(svc_p), .tmr_pending_i(tmr_p),
    .ext_pending_i(ext_p),
    .nmi_pend_o(nmi_s), .svc_pend_set_o(svc_s), .svc_pend_clr_o(svc_c),
    .tmr_pend_set_o(tmr_s), .tmr_pend_clr_o(tmr_c), .ext_pend_o(ext_s),
    .ext_pend_num_o(ext_num), .sys_reset_req_o(rreq),
    .vec_base_o(vbase), .fault_en_o(fen)
  );

  typedef struct packed {
    logic        is_wr;
    logic [9:0]  a;
    logic [31:0] d;
    logic [3:0]  st;    // {nmi, svc, tmr, ext}
    logic [31:0] exp;   // read data expected (reads only)
    logic [6:0]  sm;    // {rst, ext, tmr_clr, tmr_set, svc_clr, svc_set, nmi}
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 10'h341, 32'h8000_0000, 4'h0, 32'h0, 7'h01, 4'd2},  // R2
    '{1'b1, 10'h341, 32'h1000_0000, 4'h0, 32'h0, 7'h02, 4'd3},  // R3 set
    '{1'b1, 10'h341, 32'h0800_0000, 4'h0, 32'h0, 7'h04, 4'd3},  // R3 clear
    '{1'b1, 10'h341, 32'h1800_0000, 4'h0, 32'h0, 7'h02, 4'd3},  // R3 both
    '{1'b1, 10'h341, 32'h0400_0000, 4'h0, 32'h0, 7'h08, 4'd4},  // R4 set
    '{1'b1, 10'h341, 32'h0200_0000, 4'h0, 32'h0, 7'h10, 4'd4},  // R4 clear
    '{1'b1, 10'h341, 32'h0600_0000, 4'h0, 32'h0, 7'h08, 4'd4},  // R4 both
    '{1'b1, 10'h341, 32'h9E00_0000, 4'h0, 32'h0, 7'h0B, 4'd3},  // R3 mixed
    '{1'b0, 10'h341, 32'h0,         4'hF, 32'h9440_0000, 7'h00, 4'd5}, // R5
    '{1'b0, 10'h341, 32'h0,         4'h5, 32'h1040_0000, 7'h00, 4'd5}, // R5
    '{1'b0, 10'h341, 32'h0,         4'h0, 32'h0, 7'h00, 4'd5},  // R5
    '{1'b1, 10'h343, 32'h05FA_0004, 4'h0, 32'h0, 7'h40, 4'd7},  // R7 key ok
    '{1'b1, 10'h343, 32'h05FB_0004, 4'h0, 32'h0, 7'h00, 4'd7},  // R7 bad key
    '{1'b1, 10'h343, 32'h05FA_0003, 4'h0, 32'h0, 7'h00, 4'd7},  // R7 no bit 2
    '{1'b0, 10'h343, 32'h0,         4'h0, 32'hFA05_0000, 7'h00, 4'd8}, // R8
    '{1'b0, 10'h001, 32'h0,         4'h0, 32'h1, 7'h00, 4'd11}, // R11
    '{1'b1, 10'h3C0, 32'h0000_003F, 4'h0, 32'h0, 7'h20, 4'd10}, // R10 top
    '{1'b1, 10'h3C0, 32'h0000_0040, 4'h0, 32'h0, 7'h00, 4'd10}, // R10 bound
    '{1'b1, 10'h3C0, 32'h0000_01FF, 4'h0, 32'h0, 7'h00, 4'd10}, // R10 max
    '{1'b1, 10'h3C0, 32'h0000_0200, 4'h0, 32'h0, 7'h20, 4'd10}, // R10 field
    '{1'b0, 10'h040, 32'h0,         4'h0, 32'h0, 7'h00, 4'd12}, // R12 read
    '{1'b1, 10'h040, 32'hFFFF_FFFF, 4'h0, 32'h0, 7'h00, 4'd12}  // R12 write
  };

  function automatic logic [6:0] strobes();
    return {rreq, ext_s, tmr_c, tmr_s, svc_c, svc_s, nmi_s};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One bus access; leaves the time at the falling edge after the sampling edge
  task automatic access(input logic w, input logic [9:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr = w; rd = ~w;
    @(negedge clk);
    wr = 1'b0; rd = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hang expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 strobes", 32'(strobes()), 32'h0);
    check("R1 vbase", vbase, 32'h0);
    check("R1 fen", 32'(fen), 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 rdata", rdata, 32'h0);
    check("R1 strobes after", 32'(strobes()), 32'h0);

    for (int i = 0; i < NV; i++) begin
      {nmi_p, svc_p, tmr_p, ext_p} = VECS[i].st;
      access(VECS[i].is_wr, VECS[i].a, VECS[i].d);
      check($sformatf("R%0d vec%0d strobes", VECS[i].req, i), 32'(strobes()), 32'(VECS[i].sm));
      if (!VECS[i].is_wr)
        check($sformatf("R%0d vec%0d rdata", VECS[i].req, i), rdata, VECS[i].exp);
      @(negedge clk);
      // R13: every strobe is gone one cycle later
      check($sformatf("R13 vec%0d fall", i), 32'(strobes()), 32'h0);
    end
    {nmi_p, svc_p, tmr_p, ext_p} = 4'h0;

    // R10: number carried with the pend
    access(1'b1, 10'h3C0, 32'h0000_0025);
    check("R10 num", 32'(ext_num), 32'h25);

    // R6: vector base masking, output and readback
    access(1'b1, 10'h342, 32'h2000_00FF);
    check("R6 out", vbase, 32'h2000_0080);
    access(1'b0, 10'h342, 32'h0);
    check("R6 read", rdata, 32'h2000_0080);

    // R9: handler enables
    access(1'b1, 10'h349, 32'hFFFF_FFFF);
    check("R9 out all", 32'(fen), 32'h7);
    access(1'b0, 10'h349, 32'h0);
    check("R9 read all", rdata, 32'h0007_0000);
    access(1'b1, 10'h349, 32'h0002_0000);
    check("R9 out one", 32'(fen), 32'h2);

    // R12: write to an unmapped offset touches nothing
    access(1'b1, 10'h344, 32'hFFFF_FFFF);
    check("R12 strobes", 32'(strobes()), 32'h0);
    check("R12 vbase kept", vbase, 32'h2000_0080);
    check("R12 fen kept", 32'(fen), 32'h2);
    access(1'b0, 10'h342, 32'h0);
    check("R12 vbase read", rdata, 32'h2000_0080);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule